// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block stands in for the device side of a small word-wide flash array. A host on a synchronous port issues either a word-program command, which carries an address and a data word, or a sector-erase command, which takes its sector from the upper address bits. An internal sequencer then runs the operation for a fixed number of clock cycles and drives `ready` low for that whole time.

While an operation runs, a read of the affected word returns a status word in place of the array contents. For a program, the affected word is the target address. For an erase, it is any word of the target sector. Reads of every other word return normal array data.

Erase fills a sector with all ones. Programming can only clear bits, so a word never gains a 1 bit. A program that asks for a 1 where the array holds a 0 still stores the bitwise AND of the old and new data. It then keeps the engine busy until the timeout count runs out and raises an error flag in the status word. The error stays visible until the host's next command is accepted.

Top module: `flash_status_engine`

## Requirements
- R1: After reset, `ready` is 1 and every word reads 0xFF.
- R2: An accepted program whose data sets no bit that the array holds at 0 keeps `ready` low for exactly PROG_CYCLES cycles after the accepting edge. Afterwards the word reads as the old word ANDed with the data.
- R3: While a program runs, a read of its target address returns a status word. Bit 7 of that word is the complement of bit 7 of the program data, and all other bits are 0.
- R4: An accepted erase keeps `ready` low for exactly ERASE_CYCLES cycles. The sector is `cmdAddr[ADDR_W-1 -: SECT_W]`. Afterwards every word of that sector reads all ones, and words of other sectors keep their values.
- R5: While an erase runs, a read of any address in the target sector returns 0x00, meaning bit 7 is 0 and the error flag in bit 5 is 0.
- R6: During an operation, reads of addresses outside the target word (program) or target sector (erase) return array data.
- R7: A program whose data has a 1 where the stored word has a 0 keeps `ready` low for TIMEOUT_CYCLES cycles and stores the old word ANDed with the data. After it finishes, reads of the target return bit 7 as the complement of data bit 7 and bit 5 as 1, with all other bits 0.
- R8: A command presented while `ready` is 0 is ignored. It changes no array word and does not alter the running operation.
- R9: The latched error status clears when the next command is accepted. From then on, the old target reads as array data unless the new operation covers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request; accepted on a rising edge when `ready` is 1 |
| cmdErase | input | 1 | 1 = sector erase, 0 = word program |
| cmdAddr | input | ADDR_W | Word address; the upper SECT_W bits select the sector for an erase |
| cmdData | input | DATA_W | Program data (ignored for an erase) |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read result: array data or status word |
| ready | output | 1 | 1 when no embedded operation is running |

## Verification
Most internal faults surface on `rdData` or `ready` within one cycle of the operation they corrupt. A wrong cycle counter or limit moves the falling or rising edge of `ready`. A wrong region decode makes a status word appear on an unrelated address, or array data appear on the busy word, during the first busy cycle. A corrupted write shows only when the word is read back after completion, so every operation ends with a read of its target. Ignored commands are checked by re-reading their addresses once the running operation has finished.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } flashOp_e;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic accept;
    logic commitProg;
    logic commitErase;
    logic busy;
    logic opErase;
    logic errLatched;
  } ctlStrobe_t;

endpackage

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import flash_status_pkg::*;
#(
  parameter int PROG_CYCLES    = 6,
  parameter int ERASE_CYCLES   = 14,
  parameter int TIMEOUT_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  flashOp_e   cmdOp,
  input  logic       badBits,
  output ctlStrobe_t ctl
);

  localparam int MAX_C = (PROG_CYCLES > ERASE_CYCLES) ?
                         ((PROG_CYCLES > TIMEOUT_CYCLES) ? PROG_CYCLES : TIMEOUT_CYCLES) :
                         ((ERASE_CYCLES > TIMEOUT_CYCLES) ? ERASE_CYCLES : TIMEOUT_CYCLES);
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PROG_L  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_L = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] TOUT_L  = CNT_W'(TIMEOUT_CYCLES);
  localparam logic ERASE_OVER = (ERASE_CYCLES > TIMEOUT_CYCLES);

  logic             busyQ;
  flashOp_e         opQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitQ;
  logic             failQ;
  logic             errQ;

  logic             accept;
  logic             lastCycle;
  logic             failNext;
  logic [CNT_W-1:0] limitNext;

  always_comb begin
    accept    = cmdValid && !busyQ;
    lastCycle = busyQ && (cnt == limitQ - 1'b1);
    failNext  = (cmdOp == OP_PROG) ? badBits : ERASE_OVER;
    if (failNext)              limitNext = TOUT_L;
    else if (cmdOp == OP_PROG) limitNext = PROG_L;
    else                       limitNext = ERASE_L;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      opQ    <= OP_PROG;
      cnt    <= '0;
      limitQ <= PROG_L;
      failQ  <= 1'b0;
      errQ   <= 1'b0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      opQ    <= cmdOp;
      cnt    <= '0;
      limitQ <= limitNext;
      failQ  <= failNext;
      errQ   <= 1'b0;
    end else if (lastCycle) begin
      busyQ  <= 1'b0;
      errQ   <= failQ;
    end else if (busyQ) begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    ctl.accept      = accept;
    ctl.commitProg  = lastCycle && (opQ == OP_PROG);
    ctl.commitErase = lastCycle && (opQ == OP_ERASE) && !failQ;
    ctl.busy        = busyQ;
    ctl.opErase     = (opQ == OP_ERASE);
    ctl.errLatched  = errQ;
  end

  // R2: the running count never reaches its limit while busy
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cnt < limitQ));

  // R7: an error appears only at the edge where the operation ends
  assert_err_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $fell(busyQ));

  // R8: a command during busy does not retarget the operation
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdValid) |=> ($stable(opQ) && $stable(limitQ)));

endmodule

// File: rtl/fse_datapath.sv
module fse_datapath
  import flash_status_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              badBits
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int POLL_BIT = 7;
  localparam int ERR_BIT  = 5;
  localparam int OFF_W    = ADDR_W - SECT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;
  logic [SECT_W-1:0] tgtSector;

  assign tgtSector = tgtAddr[ADDR_W-1 -: SECT_W];
  assign badBits   = |(cmdData & ~mem[cmdAddr]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
    end else if (ctl.accept) begin
      tgtAddr <= cmdAddr;
      tgtData <= cmdData;
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : gWord
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    always_ff @(posedge clk) begin
      if (!rstN)
        mem[w] <= '1;
      else if (ctl.commitErase && (WA[ADDR_W-1 -: SECT_W] == tgtSector))
        mem[w] <= '1;
      else if (ctl.commitProg && (tgtAddr == WA))
        mem[w] <= mem[w] & tgtData;
    end
  end

  logic              inRegion;
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    inRegion = ctl.opErase ? (rdAddr[ADDR_W-1 -: SECT_W] == tgtSector)
                           : (rdAddr == tgtAddr);
    statusWord           = '0;
    statusWord[POLL_BIT] = ctl.opErase ? 1'b0 : ~tgtData[POLL_BIT];
    statusWord[ERR_BIT]  = ctl.errLatched;
    rdData = ((ctl.busy || ctl.errLatched) && inRegion) ? statusWord : mem[rdAddr];
  end

  // R2: a finished program leaves no 1 where the data had a 0
  assert_prog_clears_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitProg |=> ((mem[tgtAddr] & ~tgtData) == '0));

  // R4: the first word of an erased sector holds all ones
  assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitErase |=> (mem[{tgtSector, {OFF_W{1'b0}}}] == '1));

  // R8: the target does not move while busy
  assert_target_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |=> $stable(tgtAddr));

endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
  import flash_status_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 8,
  parameter int SECT_W         = 2,
  parameter int PROG_CYCLES    = 6,
  parameter int ERASE_CYCLES   = 14,
  parameter int TIMEOUT_CYCLES = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  ctlStrobe_t ctl;
  logic       badBits;

  fse_ctrl #(
    .PROG_CYCLES   (PROG_CYCLES),
    .ERASE_CYCLES  (ERASE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (flashOp_e'(cmdErase)),
    .badBits (badBits),
    .ctl     (ctl)
  );

  fse_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SECT_W(SECT_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cmdAddr(cmdAddr),
    .cmdData(cmdData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .badBits(badBits)
  );

  assign ready = !ctl.busy;

endmodule

// File: tb/flash_status_engine_test.sv
`timescale 1ns/1ps
module flash_status_engine_test;

  localparam int AW = 6, DW = 8, SW = 2;
  localparam int PR = 6, ER = 14, TO = 30;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdErase = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic          ready;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [DEPTH];

  bit            prevErr = 0;
  logic [AW-1:0] prevAddr = '0;

  always #4 clk = ~clk;

  flash_status_engine #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_W(SW),
    .PROG_CYCLES(PR), .ERASE_CYCLES(ER), .TIMEOUT_CYCLES(TO)
  ) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdErase(cmdErase),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdAddr(rdAddr),
    .rdData(rdData), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expStatus(input bit erase, input logic [DW-1:0] d,
                                              input bit err);
    logic [DW-1:0] s = '0;
    s[7] = erase ? 1'b0 : ~d[7];
    s[5] = err;
    return s;
  endfunction

  function automatic bit inRegion(input bit erase, input logic [AW-1:0] tgt,
                                  input logic [AW-1:0] a);
    if (erase) return a[AW-1 -: SW] == tgt[AW-1 -: SW];
    return a == tgt;
  endfunction

  task automatic readCheck(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                           input string req, input string what);
    rdAddr = a;
    #1;
    check(rdData === exp, req, what, int'(rdData), int'(exp));
  endtask

  task automatic runOp(input bit erase, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    bit            bad;
    int            expLen;
    int            cycles;
    logic [AW-1:0] spurAddr;
    logic [AW-1:0] other;
    bad    = !erase && (|(data & ~model[addr]));
    expLen = bad ? TO : (erase ? ER : PR);
    spurAddr = addr;
    @(negedge clk);
    cmdValid = 1'b1; cmdErase = erase; cmdAddr = addr; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    cycles = 0;
    while (!ready && cycles < expLen + 10) begin
      if (cycles == 0 && prevErr && !inRegion(erase, addr, prevAddr))
        readCheck(prevAddr, model[prevAddr], "R9", "old error target after new accept");
      if (erase)
        readCheck({addr[AW-1 -: SW], (AW-SW)'($urandom)}, expStatus(1, data, 0),
                  "R5", "erase status in sector");
      else
        readCheck(addr, expStatus(0, data, 0), "R3", "program status at target");
      other = erase ? {addr[AW-1 -: SW] + 1'b1, (AW-SW)'($urandom)} : addr ^ AW'(1 + ($urandom % (DEPTH-1)));
      readCheck(other, model[other], "R6", "outside read during busy");
      if (cycles == 1) begin
        spurAddr = AW'($urandom);
        cmdValid = 1'b1; cmdErase = $urandom % 2; cmdAddr = spurAddr; cmdData = '0;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    cmdValid = 1'b0;
    check(cycles == expLen, bad ? "R7" : (erase ? "R4" : "R2"), "busy length", cycles, expLen);
    if (erase) begin
      for (int i = 0; i < DEPTH; i++)
        if (inRegion(1, addr, AW'(i))) model[i] = '1;
      for (int i = 0; i < (1 << (AW-SW)); i++)
        readCheck({addr[AW-1 -: SW], (AW-SW)'(i)}, 8'hFF, "R4", "erased word");
      other = {addr[AW-1 -: SW] + 1'b1, (AW-SW)'($urandom)};
      readCheck(other, model[other], "R4", "word in other sector");
    end else begin
      model[addr] = model[addr] & data;
      if (bad) readCheck(addr, expStatus(0, data, 1), "R7", "error status after timeout");
      else     readCheck(addr, model[addr], "R2", "programmed word");
    end
    if (!(bad && spurAddr == addr))
      readCheck(spurAddr, model[spurAddr], "R8", "command during busy ignored");
    prevErr  = bad;
    prevAddr = addr;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);
    for (int i = 0; i < DEPTH; i += 9) readCheck(AW'(i), 8'hFF, "R1", "reset contents");

    // directed corner cases
    runOp(0, 6'd5, 8'h00);   // clear all bits
    runOp(0, 6'd5, 8'hFF);   // asks for ones over zeros: timeout error
    readCheck(6'd5, expStatus(0, 8'hFF, 1), "R7", "error still latched while idle");
    runOp(0, 6'd6, 8'h80);   // clears error, bit 7 set in data
    runOp(0, 6'd6, 8'h8F);   // bad bits 0x0F, stores 0x80
    runOp(1, 6'd3, 8'h00);   // erase sector 0 holding the old error target
    readCheck(6'd6, 8'hFF, "R9", "erased error word reads data");
    runOp(0, 6'd20, 8'h7E);
    runOp(1, 6'd63, 8'h00);

    for (int n = 0; n < 60; n++) begin
      bit            e = ($urandom % 4) == 0;
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      runOp(e, a, d);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule